// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit resolves where a small microcontroller core fetches next after a control-flow instruction, and how many cycles that instruction holds the pipeline. The decoder gives it the current program counter, an operation class, an offset field or an absolute target, a status-bit select with a polarity, the status register, and the facts a skip needs: a register-equality flag, a tested bit value, and whether the instruction after the skip is two words long.

Each clock edge the unit registers three results: the next program counter, a flag that says control left the sequential path, and the cycle count. Conditional branches test one status bit, or the signed less-than term formed from the negative and overflow bits. Skips step over one or two words. Relative, indirect and direct jumps are always taken. The program counter wraps modulo its width. Stack handling for calls and returns, and instruction fetch, belong elsewhere.

Top module: `bsd_unit`

## Requirements
- R1: While `rst_i` is high and on the first edge after it, `next_pc_o`, `taken_o` and `cycles_o` are all zero.
- R2: Operation code 0 (sequential), and the unused code 7, give `next_pc_o` = PC+1, `taken_o` = 0 and `cycles_o` = 1.
- R3: Operation code 1 (status-bit branch) is taken when `sreg_i[sel_i]` equals `pol_i`. Taken gives PC + sign-extended `offset_i[6:0]` + 1 with 2 cycles. Not taken gives PC+1 with 1 cycle.
- R4: Operation code 2 (signed branch) uses N = `sreg_i[2]` and V = `sreg_i[3]`. With `pol_i` = 0 it is taken when N XOR V = 0 (greater or equal). With `pol_i` = 1 it is taken when N XOR V = 1 (less than). Target and cycle counts are as in R3, and `sel_i` is ignored.
- R5: Operation code 3 (skip) skips according to `skip_mode_i`: 0 skips when `eq_i` = 1, 1 skips when `tbit_i` = 0, 2 skips when `tbit_i` = 1, and 3 never skips. A skip that does not fire gives PC+1, 1 cycle and `taken_o` = 0.
- R6: A skip that fires gives `taken_o` = 1. It gives PC+2 with 2 cycles when `two_word_i` = 0, and PC+3 with 3 cycles when `two_word_i` = 1.
- R7: Operation code 4 (relative jump) is always taken and gives PC + sign-extended `offset_i[11:0]` + 1 with 2 cycles.
- R8: Operation code 5 (indirect jump) gives `target_i` with 2 cycles. Operation code 6 (direct jump) gives `target_i` with 3 cycles. Both report `taken_o` = 1.
- R9: All program-counter sums wrap modulo 2^PC_W. Bits `offset_i[11:7]` have no effect on a conditional branch.
- R10: Outputs reflect the inputs sampled at the previous rising edge of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_i | input | PC_W | Address of the current instruction |
| op_i | input | 3 | Operation class code |
| offset_i | input | 12 | Signed offset field; the low 7 bits are used by conditional branches |
| target_i | input | PC_W | Absolute or pointer target for jumps |
| sel_i | input | 3 | Status bit index for the status-bit branch |
| pol_i | input | 1 | Condition polarity: 1 = taken when the bit or term is set |
| sreg_i | input | 8 | Status register |
| skip_mode_i | input | 2 | Skip condition select |
| eq_i | input | 1 | Register equality result for the equality skip |
| tbit_i | input | 1 | Tested register or I/O bit for the bit skips |
| two_word_i | input | 1 | The following instruction is two words long |
| next_pc_o | output | PC_W | Resolved next program counter |
| taken_o | output | 1 | Control left the sequential path |
| cycles_o | output | 2 | Cycles the instruction consumes |

## Verification
The bench drives negative offsets across address zero and large positive jumps past the top of the address space. A design that drops the wrap or extends with zeros lands far from the expected address. It sets junk in the upper offset bits during conditional branches, which exposes a branch that sign-extends the wrong width. It pairs set and clear polarity with N and V in all four combinations, so a swapped bit index or an inverted signed term shows up as a wrong taken flag. Skips are tried with both instruction lengths and all four condition modes, where an off-by-one step or a cycle count taken from the wrong source is visible at once.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int CYC_W = 2;

    typedef enum logic [2:0] {
        OP_SEQ   = 3'd0,
        OP_BRBIT = 3'd1,
        OP_BRSGN = 3'd2,
        OP_SKIP  = 3'd3,
        OP_RJMP  = 3'd4,
        OP_IJMP  = 3'd5,
        OP_JMP   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SK_EQ   = 2'd0,
        SK_CLR  = 2'd1,
        SK_SET  = 2'd2,
        SK_NONE = 2'd3
    } skip_mode_e;

    localparam int N_BIT = 2;
    localparam int V_BIT = 3;

endpackage

// File: rtl/bsd_cond.sv
module bsd_cond
    import bsd_pkg::*;
#(
    parameter int SREG_W = 8,
    localparam int SEL_W = $clog2(SREG_W)
) (
    input  logic [2:0]        op_i,
    input  logic [SREG_W-1:0] sreg_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pol_i,
    input  logic [1:0]        skip_mode_i,
    input  logic              eq_i,
    input  logic              tbit_i,
    output logic              cond_o
);

    logic sgn_lt;
    logic skip_hit;

    assign sgn_lt = sreg_i[N_BIT] ^ sreg_i[V_BIT];

    always_comb begin
        unique case (skip_mode_e'(skip_mode_i))
            SK_EQ:   skip_hit = eq_i;
            SK_CLR:  skip_hit = ~tbit_i;
            SK_SET:  skip_hit = tbit_i;
            default: skip_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (op_e'(op_i))
            OP_BRBIT: cond_o = (sreg_i[sel_i] == pol_i);
            OP_BRSGN: cond_o = (sgn_lt == pol_i);
            OP_SKIP:  cond_o = skip_hit;
            default:  cond_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bsd_target.sv
module bsd_target #(
    parameter int PC_W  = 16,
    parameter int BR_W  = 7,
    parameter int RJ_W  = 12
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [RJ_W-1:0] offset_i,
    output logic [PC_W-1:0] step_pc_o,
    output logic [PC_W-1:0] br_pc_o,
    output logic [PC_W-1:0] rj_pc_o,
    output logic [PC_W-1:0] skip1_pc_o,
    output logic [PC_W-1:0] skip2_pc_o
);

    logic [PC_W-1:0] br_ext;
    logic [PC_W-1:0] rj_ext;

    assign br_ext = {{(PC_W-BR_W){offset_i[BR_W-1]}}, offset_i[BR_W-1:0]};
    assign rj_ext = {{(PC_W-RJ_W){offset_i[RJ_W-1]}}, offset_i};

    assign step_pc_o  = pc_i + PC_W'(1);
    assign skip1_pc_o = pc_i + PC_W'(2);
    assign skip2_pc_o = pc_i + PC_W'(3);
    assign br_pc_o    = step_pc_o + br_ext;
    assign rj_pc_o    = step_pc_o + rj_ext;

endmodule

// File: rtl/bsd_unit.sv
module bsd_unit
    import bsd_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int SREG_W = 8,
    parameter int BR_W   = 7,
    parameter int RJ_W   = 12,
    localparam int SEL_W = $clog2(SREG_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [2:0]        op_i,
    input  logic [RJ_W-1:0]   offset_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pol_i,
    input  logic [SREG_W-1:0] sreg_i,
    input  logic [1:0]        skip_mode_i,
    input  logic              eq_i,
    input  logic              tbit_i,
    input  logic              two_word_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic [CYC_W-1:0]  cycles_o
);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic             taken;
        logic [CYC_W-1:0] cycles;
        logic             primed;
    } res_t;

    res_t res_d, res_q;

    logic            cond;
    logic [PC_W-1:0] step_pc, br_pc, rj_pc, skip1_pc, skip2_pc;

    bsd_cond #(.SREG_W(SREG_W)) cond_i (
        .op_i        (op_i),
        .sreg_i      (sreg_i),
        .sel_i       (sel_i),
        .pol_i       (pol_i),
        .skip_mode_i (skip_mode_i),
        .eq_i        (eq_i),
        .tbit_i      (tbit_i),
        .cond_o      (cond)
    );

    bsd_target #(.PC_W(PC_W), .BR_W(BR_W), .RJ_W(RJ_W)) target_i_u (
        .pc_i       (pc_i),
        .offset_i   (offset_i),
        .step_pc_o  (step_pc),
        .br_pc_o    (br_pc),
        .rj_pc_o    (rj_pc),
        .skip1_pc_o (skip1_pc),
        .skip2_pc_o (skip2_pc)
    );

    always_comb begin
        res_d        = '0;
        res_d.primed = 1'b1;
        res_d.pc     = step_pc;
        res_d.cycles = CYC_W'(1);
        unique case (op_e'(op_i))
            OP_BRBIT, OP_BRSGN: begin
                if (cond) begin
                    res_d.pc     = br_pc;
                    res_d.taken  = 1'b1;
                    res_d.cycles = CYC_W'(2);
                end
            end
            OP_SKIP: begin
                if (cond) begin
                    res_d.taken  = 1'b1;
                    res_d.pc     = two_word_i ? skip2_pc : skip1_pc;
                    res_d.cycles = two_word_i ? CYC_W'(3) : CYC_W'(2);
                end
            end
            OP_RJMP: begin
                res_d.pc     = rj_pc;
                res_d.taken  = 1'b1;
                res_d.cycles = CYC_W'(2);
            end
            OP_IJMP: begin
                res_d.pc     = target_i;
                res_d.taken  = 1'b1;
                res_d.cycles = CYC_W'(2);
            end
            OP_JMP: begin
                res_d.pc     = target_i;
                res_d.taken  = 1'b1;
                res_d.cycles = CYC_W'(3);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) res_q <= '0;
        else       res_q <= res_d;
    end

    assign next_pc_o = res_q.pc;
    assign taken_o   = res_q.taken;
    assign cycles_o  = res_q.cycles;

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        $past(rst_i) |-> (next_pc_o == '0 && !taken_o && cycles_o == '0)); // R1

    AST_FALLTHROUGH_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_q.primed && !taken_o) |-> (next_pc_o == $past(pc_i) + PC_W'(1) && cycles_o == CYC_W'(1))); // R2

    AST_BRANCH_TWO_CYC: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_q.primed && taken_o && ($past(op_i) == 3'(OP_BRBIT) || $past(op_i) == 3'(OP_BRSGN)))
        |-> cycles_o == CYC_W'(2)); // R3

    AST_SKIP_LENGTH: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_q.primed && taken_o && $past(op_i) == 3'(OP_SKIP))
        |-> (next_pc_o == $past(pc_i) + ($past(two_word_i) ? PC_W'(3) : PC_W'(2)))); // R6

    AST_ABS_JUMP: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_q.primed && $past(op_i) == 3'(OP_JMP))
        |-> (next_pc_o == $past(target_i) && taken_o && cycles_o == CYC_W'(3))); // R8

    AST_CYC_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        res_q.primed |-> (cycles_o != '0)); // R10

endmodule

// File: tb/bsd_unit_tb_top.sv
module bsd_unit_tb_top;
    import bsd_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pc, target;
    logic [2:0]  op, sel;
    logic [11:0] ofs;
    logic        pol, eq, tbit, tw;
    logic [7:0]  sreg;
    logic [1:0]  mode;
    logic [15:0] next_pc;
    logic        taken;
    logic [1:0]  cycles;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bsd_unit dut_i (
        .clk_i(clk), .rst_i(rst), .pc_i(pc), .op_i(op), .offset_i(ofs),
        .target_i(target), .sel_i(sel), .pol_i(pol), .sreg_i(sreg),
        .skip_mode_i(mode), .eq_i(eq), .tbit_i(tbit), .two_word_i(tw),
        .next_pc_o(next_pc), .taken_o(taken), .cycles_o(cycles)
    );

    task automatic check(string req, logic [15:0] e_pc, logic e_tk, logic [1:0] e_cy);
        checks++;
        if (next_pc !== e_pc || taken !== e_tk || cycles !== e_cy) begin
            fails++;
            $display("FAIL %s actual pc=%h tk=%b cy=%0d expected pc=%h tk=%b cy=%0d",
                     req, next_pc, taken, cycles, e_pc, e_tk, e_cy);
        end
    endtask

    task automatic drive(logic [2:0] o, logic [15:0] p, logic [11:0] f, logic [15:0] t,
                         logic [2:0] s, logic pl, logic [7:0] sr, logic [1:0] m,
                         logic e, logic b, logic w);
        @(negedge clk);
        op = o; pc = p; ofs = f; target = t; sel = s; pol = pl; sreg = sr;
        mode = m; eq = e; tbit = b; tw = w;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(3'(OP_JMP), 16'h1234, 12'h0, 16'hBEEF, 3'd0, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R1 during reset", 16'h0, 1'b0, 2'd0);
        rst = 1'b0;
    endtask

    task automatic t_seq();
        drive(3'(OP_SEQ), 16'h0100, 12'h7FF, 16'hAAAA, 3'd1, 1'b1, 8'hFF, 2'd0, 1'b1, 1'b1, 1'b1);
        check("R2 sequential", 16'h0101, 1'b0, 2'd1);
        drive(3'(OP_RSVD), 16'h2000, 12'h123, 16'h5555, 3'd0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0);
        check("R2 unused code", 16'h2001, 1'b0, 2'd1);
    endtask

    task automatic t_brbit();
        drive(3'(OP_BRBIT), 16'h0100, 12'h03F, 16'h0, 3'd1, 1'b1, 8'h02, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R3 bit set taken fwd", 16'h0140, 1'b1, 2'd2);
        drive(3'(OP_BRBIT), 16'h0100, 12'h07F, 16'h0, 3'd1, 1'b0, 8'h02, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R3 bit clear not taken", 16'h0101, 1'b0, 2'd1);
        drive(3'(OP_BRBIT), 16'h0100, 12'h07F, 16'h0, 3'd0, 1'b0, 8'hFE, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R3 bit clear taken back", 16'h0100, 1'b1, 2'd2);
        drive(3'(OP_BRBIT), 16'h0100, 12'hF85, 16'h0, 3'd7, 1'b1, 8'h80, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R9 upper offset bits ignored", 16'h0106, 1'b1, 2'd2);
    endtask

    task automatic t_brsgn();
        // N = bit 2, V = bit 3
        drive(3'(OP_BRSGN), 16'h0300, 12'h010, 16'h0, 3'd5, 1'b0, 8'h0C, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R4 GE N=1 V=1 taken", 16'h0311, 1'b1, 2'd2);
        drive(3'(OP_BRSGN), 16'h0300, 12'h010, 16'h0, 3'd5, 1'b0, 8'h04, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R4 GE N=1 V=0 not taken", 16'h0301, 1'b0, 2'd1);
        drive(3'(OP_BRSGN), 16'h0300, 12'h010, 16'h0, 3'd2, 1'b1, 8'h08, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R4 LT N=0 V=1 taken", 16'h0311, 1'b1, 2'd2);
        drive(3'(OP_BRSGN), 16'h0300, 12'h010, 16'h0, 3'd2, 1'b1, 8'hF3, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R4 LT N=0 V=0 not taken", 16'h0301, 1'b0, 2'd1);
    endtask

    task automatic t_skip();
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd0, 1'b1, 1'b0, 1'b0);
        check("R6 equal skip one word", 16'h0402, 1'b1, 2'd2);
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd0, 1'b0, 1'b1, 1'b1);
        check("R5 equal no skip", 16'h0401, 1'b0, 2'd1);
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd1, 1'b0, 1'b0, 1'b1);
        check("R6 bit clear skip two words", 16'h0403, 1'b1, 2'd3);
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd1, 1'b1, 1'b1, 1'b1);
        check("R5 bit clear no skip", 16'h0401, 1'b0, 2'd1);
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd2, 1'b0, 1'b1, 1'b1);
        check("R6 bit set skip two words", 16'h0403, 1'b1, 2'd3);
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd2, 1'b1, 1'b0, 1'b0);
        check("R5 bit set no skip", 16'h0401, 1'b0, 2'd1);
        drive(3'(OP_SKIP), 16'h0400, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd3, 1'b1, 1'b1, 1'b1);
        check("R5 mode 3 never skips", 16'h0401, 1'b0, 2'd1);
    endtask

    task automatic t_jumps();
        drive(3'(OP_RJMP), 16'h0100, 12'hF85, 16'h0, 3'd0, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R7 relative back", 16'h0086, 1'b1, 2'd2);
        drive(3'(OP_IJMP), 16'h0100, 12'h0, 16'hC0DE, 3'd0, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R8 indirect", 16'hC0DE, 1'b1, 2'd2);
        drive(3'(OP_JMP), 16'h0100, 12'h0, 16'h7A7A, 3'd0, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 1'b1);
        check("R8 direct", 16'h7A7A, 1'b1, 2'd3);
    endtask

    task automatic t_wrap();
        drive(3'(OP_RJMP), 16'hFFFF, 12'h7FF, 16'h0, 3'd0, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R9 relative wraps high", 16'h07FF, 1'b1, 2'd2);
        drive(3'(OP_BRBIT), 16'h0000, 12'h040, 16'h0, 3'd0, 1'b1, 8'h01, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R9 branch wraps low", 16'hFFC1, 1'b1, 2'd2);
        drive(3'(OP_SKIP), 16'hFFFE, 12'h0, 16'h0, 3'd0, 1'b0, 8'h0, 2'd0, 1'b1, 1'b0, 1'b1);
        check("R9 skip wraps", 16'h0001, 1'b1, 2'd3);
    endtask

    task automatic t_latency();
        // R10: a change at the inputs is seen only after the next rising edge
        @(negedge clk);
        op = 3'(OP_JMP); target = 16'h0F0F;
        @(posedge clk); #1;
        check("R10 after edge", 16'h0F0F, 1'b1, 2'd3);
        @(negedge clk);
        target = 16'h3C3C;
        #2;
        check("R10 held between edges", 16'h0F0F, 1'b1, 2'd3);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op = '0; pc = '0; ofs = '0; target = '0; sel = '0; pol = 1'b0;
        sreg = '0; mode = '0; eq = 1'b0; tbit = 1'b0; tw = 1'b0;
        t_reset();
        t_seq();
        t_brbit();
        t_brsgn();
        t_skip();
        t_jumps();
        t_wrap();
        t_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule